// File: doc/BRIEF.md
# Boot Mode Reset Dispatcher

This controller runs once each time the chip leaves reset and decides where instruction fetch begins. On the first clock after reset is released it latches a two-bit boot-mode strap and a software-reset status flag. The flag is bit 4 of the reset configuration register. After that capture, both values are frozen until the next reset.

In the following cycle the controller makes its decision. A software reset, or strap code 00, skips any load: the fetch vector and the jump indication are produced at once. Every other strap code points the fetch vector at the boot ROM and fires a one-cycle, one-hot start pulse at one of three loaders: parallel flash, SPI slave or SPI master. The controller then waits for that loader's done bit and publishes a sticky jump to the start of L1 memory.

When flash loading is chosen, the controller also drives the timing for external asynchronous bank 0. It enables the bank and sets a 3-cycle hold and a 15-cycle access wait.

Top module: `reset_boot_dispatcher`

## Requirements
- R1: While reset (rstN low) is active, every output is zero: bootVector, loaderStart, bankEnable, bankHold, bankWait, jumpValid and jumpAddr.
- R2: strapMode and swResetFlag are captured on the first rising clock edge after rstN goes high. Changes to them after that edge have no effect on any output until the next reset.
- R3: If the captured swResetFlag is 1, bootVector and jumpAddr become 0xFFA0_0000 and jumpValid becomes 1 after the second edge after reset release. No start pulse is issued, whatever the strap value.
- R4: If the flag is 0 and strap code 00 was captured, bootVector and jumpAddr become the external bank 0 base (EXT_BASE, 0x2000_0000 by default) and jumpValid becomes 1 after the second edge. No start pulse is issued.
- R5: If the flag is 0 and the strap code is 01, 10 or 11, bootVector becomes 0xEF00_0000 after the second edge. In the same cycle exactly one loaderStart bit is set: bit 0 (flash) for 01, bit 1 (SPI slave) for 10, and bit 2 (SPI master) for 11.
- R6: A loaderStart pulse lasts exactly one clock cycle and is never repeated before the next reset.
- R7: For strap 01, bankEnable becomes 1, bankHold becomes 3 and bankWait becomes 15 in the same cycle as the start pulse, and they hold there. For every other outcome they stay 0.
- R8: After a start pulse, only the done bit with the same index as the pulse ends the wait; done bits of other loaders are ignored. One edge after the matching done bit is sampled high, jumpValid becomes 1 with jumpAddr 0xFFA0_0000.
- R9: Once jumpValid is 1, it and jumpAddr stay unchanged until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| strapMode | input | 2 | Boot-mode strap pins |
| swResetFlag | input | 1 | Software-reset status, bit 4 of the reset configuration register |
| loaderDone | input | 3 | Completion bits from the flash, SPI slave and SPI master loaders |
| bootVector | output | ADDR_W | Address where the core starts fetching |
| loaderStart | output | 3 | One-hot, single-cycle start pulse to the selected loader |
| bankEnable | output | 1 | Enable for external asynchronous bank 0 |
| bankHold | output | $clog2(FLASH_HOLD+1) | Bank 0 hold time in cycles |
| bankWait | output | $clog2(FLASH_WAIT+1) | Bank 0 access wait states |
| jumpValid | output | 1 | Boot finished; jumpAddr is valid |
| jumpAddr | output | ADDR_W | Final fetch address after boot |

## Verification
The bench builds the block with its default parameters. At these values the ROM base, L1 start and external base match their required addresses, and the bank timing fields are exactly wide enough to hold 3 and 15. With these defaults the bench can compare every decoded address against a literal constant. It can also check the full-scale value of the wait field. Driving a done bit from a loader that was not selected, and changing the straps after capture, tests that the wait and the capture ignore the wrong inputs.

// File: rtl/boot_dispatch_pkg.sv
package boot_dispatch_pkg;

  localparam int NUM_LOADERS = 3;

  typedef enum logic [1:0] {
    MODE_EXT        = 2'b00,
    MODE_FLASH      = 2'b01,
    MODE_SPI_SLAVE  = 2'b10,
    MODE_SPI_MASTER = 2'b11
  } bootMode_e;

  typedef struct packed {
    logic capture;
    logic fire;
    logic finish;
  } ctlStrobe_t;

endpackage

// File: rtl/boot_dispatch_ctrl.sv
module boot_dispatch_ctrl
  import boot_dispatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bypass,
  input  logic       doneHit,
  output ctlStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_CAPTURE,
    ST_DECIDE,
    ST_WAIT,
    ST_DONE
  } ctlState_e;

  ctlState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CAPTURE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_CAPTURE: begin
        strobe.capture = 1'b1;
        stateNext      = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (bypass) begin
          strobe.finish = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          strobe.fire = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (doneHit) begin
          strobe.finish = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      default: stateNext = ST_DONE;
    endcase
  end

  // R8: without the matching done bit the controller keeps waiting
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !doneHit) |=> (state == ST_WAIT));

  // R3/R4: a bypass decision goes straight to the final state
  a_r3_bypass_skips_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && bypass) |=> (state == ST_DONE));

  // R9: the final state is never left
  a_r9_done_terminal: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE));

endmodule

// File: rtl/boot_dispatch_dp.sv
module boot_dispatch_dp
  import boot_dispatch_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] ROM_BASE   = 32'hEF00_0000,
  parameter logic [31:0] L1_BASE    = 32'hFFA0_0000,
  parameter logic [31:0] EXT_BASE   = 32'h2000_0000,
  parameter int          FLASH_HOLD = 3,
  parameter int          FLASH_WAIT = 15
)(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [1:0]                           strapMode,
  input  logic                                 swResetFlag,
  input  logic [NUM_LOADERS-1:0]               loaderDone,
  input  ctlStrobe_t                           strobe,
  output logic                                 bypass,
  output logic                                 doneHit,
  output logic [ADDR_W-1:0]                    bootVector,
  output logic [NUM_LOADERS-1:0]               loaderStart,
  output logic                                 bankEnable,
  output logic [$clog2(FLASH_HOLD+1)-1:0]      bankHold,
  output logic [$clog2(FLASH_WAIT+1)-1:0]      bankWait,
  output logic                                 jumpValid,
  output logic [ADDR_W-1:0]                    jumpAddr
);

  localparam int HOLD_W = $clog2(FLASH_HOLD + 1);
  localparam int WAIT_W = $clog2(FLASH_WAIT + 1);
  localparam logic [HOLD_W-1:0] HOLD_VAL = HOLD_W'(FLASH_HOLD);
  localparam logic [WAIT_W-1:0] WAIT_VAL = WAIT_W'(FLASH_WAIT);
  localparam logic [ADDR_W-1:0] ROM_ADDR = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] L1_ADDR  = ADDR_W'(L1_BASE);
  localparam logic [ADDR_W-1:0] EXT_ADDR = ADDR_W'(EXT_BASE);

  bootMode_e modeQ;
  logic      swRstQ;
  logic [NUM_LOADERS-1:0] selOnehot;
  logic [ADDR_W-1:0]      jumpTarget;

  // loader index i serves strap code i+1
  for (genvar i = 0; i < NUM_LOADERS; i++) begin : g_sel
    assign selOnehot[i] = (modeQ == bootMode_e'(i + 1));
  end

  assign bypass     = swRstQ || (modeQ == MODE_EXT);
  assign doneHit    = |(loaderDone & selOnehot);
  assign jumpTarget = (!swRstQ && modeQ == MODE_EXT) ? EXT_ADDR : L1_ADDR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_EXT;
      swRstQ      <= 1'b0;
      bootVector  <= '0;
      loaderStart <= '0;
      bankEnable  <= 1'b0;
      bankHold    <= '0;
      bankWait    <= '0;
      jumpValid   <= 1'b0;
      jumpAddr    <= '0;
    end else begin
      if (strobe.capture) begin
        modeQ  <= bootMode_e'(strapMode);
        swRstQ <= swResetFlag;
      end
      loaderStart <= strobe.fire ? selOnehot : '0;
      if (strobe.fire) begin
        bootVector <= ROM_ADDR;
        if (modeQ == MODE_FLASH) begin
          bankEnable <= 1'b1;
          bankHold   <= HOLD_VAL;
          bankWait   <= WAIT_VAL;
        end
      end
      if (strobe.finish) begin
        jumpValid <= 1'b1;
        jumpAddr  <= jumpTarget;
        if (bypass) bootVector <= jumpTarget;
      end
    end
  end

  // R5: never more than one loader started
  a_r5_start_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loaderStart));

  // R6: a start pulse is one cycle wide
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (loaderStart != '0) |=> (loaderStart == '0));

  // R2: captured straps do not move after the capture cycle
  a_r2_capture_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(modeQ) && $stable(swRstQ)));

  // R9: the jump indication is sticky
  a_r9_jump_sticky: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |=> (jumpValid && $stable(jumpAddr)));

  // R3: a software reset never starts a loader
  a_r3_no_start_on_swreset: assert property (@(posedge clk) disable iff (!rstN)
    swRstQ |-> (loaderStart == '0));

endmodule

// File: rtl/reset_boot_dispatcher.sv
module reset_boot_dispatcher
  import boot_dispatch_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] ROM_BASE   = 32'hEF00_0000,
  parameter logic [31:0] L1_BASE    = 32'hFFA0_0000,
  parameter logic [31:0] EXT_BASE   = 32'h2000_0000,
  parameter int          FLASH_HOLD = 3,
  parameter int          FLASH_WAIT = 15
)(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      strapMode,
  input  logic                            swResetFlag,
  input  logic [2:0]                      loaderDone,
  output logic [ADDR_W-1:0]               bootVector,
  output logic [2:0]                      loaderStart,
  output logic                            bankEnable,
  output logic [$clog2(FLASH_HOLD+1)-1:0] bankHold,
  output logic [$clog2(FLASH_WAIT+1)-1:0] bankWait,
  output logic                            jumpValid,
  output logic [ADDR_W-1:0]               jumpAddr
);

  ctlStrobe_t strobe;
  logic       bypass;
  logic       doneHit;

  boot_dispatch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bypass  (bypass),
    .doneHit (doneHit),
    .strobe  (strobe)
  );

  boot_dispatch_dp #(
    .ADDR_W     (ADDR_W),
    .ROM_BASE   (ROM_BASE),
    .L1_BASE    (L1_BASE),
    .EXT_BASE   (EXT_BASE),
    .FLASH_HOLD (FLASH_HOLD),
    .FLASH_WAIT (FLASH_WAIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strapMode   (strapMode),
    .swResetFlag (swResetFlag),
    .loaderDone  (loaderDone),
    .strobe      (strobe),
    .bypass      (bypass),
    .doneHit     (doneHit),
    .bootVector  (bootVector),
    .loaderStart (loaderStart),
    .bankEnable  (bankEnable),
    .bankHold    (bankHold),
    .bankWait    (bankWait),
    .jumpValid   (jumpValid),
    .jumpAddr    (jumpAddr)
  );

endmodule

// File: tb/reset_boot_dispatcher_bench.sv
module reset_boot_dispatcher_bench;

  localparam logic [31:0] ROM  = 32'hEF00_0000;
  localparam logic [31:0] L1   = 32'hFFA0_0000;
  localparam logic [31:0] EXTB = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  strapMode = 2'b00;
  logic        swResetFlag = 1'b0;
  logic [2:0]  loaderDone = 3'b000;
  logic [31:0] bootVector;
  logic [2:0]  loaderStart;
  logic        bankEnable;
  logic [1:0]  bankHold;
  logic [3:0]  bankWait;
  logic        jumpValid;
  logic [31:0] jumpAddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reset_boot_dispatcher u_reset_boot_dispatcher (
    .clk(clk), .rstN(rstN), .strapMode(strapMode), .swResetFlag(swResetFlag),
    .loaderDone(loaderDone), .bootVector(bootVector), .loaderStart(loaderStart),
    .bankEnable(bankEnable), .bankHold(bankHold), .bankWait(bankWait),
    .jumpValid(jumpValid), .jumpAddr(jumpAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reset, then release at a falling edge; returns after the capture edge
  task automatic bootUp(input logic [1:0] mode, input logic sw);
    rstN = 1'b0; strapMode = mode; swResetFlag = sw; loaderDone = 3'b000;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rstN = 1'b0; strapMode = 2'b01;
    repeat (2) @(negedge clk);
    check(bootVector == 0 && jumpAddr == 0, "R1 addresses", bootVector, 0);
    check(loaderStart == 0 && !jumpValid, "R1 start/jump", {29'd0, loaderStart}, 0);
    check(!bankEnable && bankHold == 0 && bankWait == 0, "R1 bank", {26'd0, bankEnable, bankHold, bankWait}, 0);
  endtask

  task automatic t_sw_reset(input logic [1:0] mode);
    bootUp(mode, 1'b1);
    @(negedge clk);
    check(bootVector == L1, "R3 vector", bootVector, L1);
    check(jumpValid && jumpAddr == L1, "R3 jump", jumpAddr, L1);
    check(loaderStart == 0, "R3 no start", {29'd0, loaderStart}, 0);
    check(!bankEnable, "R7 bank off on sw reset", {31'd0, bankEnable}, 0);
  endtask

  task automatic t_ext_bypass();
    bootUp(2'b00, 1'b0);
    @(negedge clk);
    check(bootVector == EXTB, "R4 vector", bootVector, EXTB);
    check(jumpValid && jumpAddr == EXTB, "R4 jump", jumpAddr, EXTB);
    check(loaderStart == 0, "R4 no start", {29'd0, loaderStart}, 0);
    check(!bankEnable && bankWait == 0, "R7 bank off on ext", {27'd0, bankEnable, bankWait}, 0);
  endtask

  task automatic t_loader(input logic [1:0] mode);
    logic [2:0] sel = 3'b001 << (mode - 2'd1);
    bootUp(mode, 1'b0);
    @(negedge clk);
    check(bootVector == ROM, "R5 vector", bootVector, ROM);
    check(loaderStart == sel, "R5 start select", {29'd0, loaderStart}, {29'd0, sel});
    if (mode == 2'b01)
      check(bankEnable && bankHold == 2'd3 && bankWait == 4'd15, "R7 flash timing",
            {26'd0, bankEnable, bankHold, bankWait}, {26'd0, 1'b1, 2'd3, 4'd15});
    else
      check(!bankEnable && bankHold == 0 && bankWait == 0, "R7 bank idle",
            {26'd0, bankEnable, bankHold, bankWait}, 0);
    @(negedge clk);
    check(loaderStart == 0, "R6 pulse one cycle", {29'd0, loaderStart}, 0);
    check(!jumpValid, "R8 no jump before done", {31'd0, jumpValid}, 0);
    loaderDone = ~sel;
    repeat (2) @(negedge clk);
    check(!jumpValid, "R8 foreign done ignored", {31'd0, jumpValid}, 0);
    check(loaderStart == 0, "R6 no repeat pulse", {29'd0, loaderStart}, 0);
    loaderDone = sel;
    @(negedge clk);
    check(jumpValid && jumpAddr == L1, "R8 jump after done", jumpAddr, L1);
    loaderDone = 3'b000;
    repeat (3) @(negedge clk);
    check(jumpValid && jumpAddr == L1, "R9 jump sticky", jumpAddr, L1);
    check(bootVector == ROM, "R9 vector held", bootVector, ROM);
  endtask

  task automatic t_late_strap();
    bootUp(2'b11, 1'b0);
    strapMode = 2'b00; swResetFlag = 1'b1;
    @(negedge clk);
    check(bootVector == ROM && loaderStart == 3'b100, "R2 late change ignored", bootVector, ROM);
    check(!jumpValid, "R2 no bypass from late flag", {31'd0, jumpValid}, 0);
    loaderDone = 3'b100;
    @(negedge clk);
    loaderDone = 3'b000;
    strapMode = 2'b01;
    repeat (2) @(negedge clk);
    check(jumpAddr == L1 && !bankEnable && loaderStart == 0, "R2 strap after jump ignored", jumpAddr, L1);
  endtask

  initial begin
    t_reset_state();
    t_sw_reset(2'b01);
    t_sw_reset(2'b00);
    t_ext_bypass();
    t_loader(2'b01);
    t_loader(2'b10);
    t_loader(2'b11);
    t_late_strap();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule